// File: doc/BRIEF.md
# Serial Configuration Slave with Response Backpressure

This block is the slave end of a four-wire serial configuration bus. The bus has a clock, a command line and a response line shared by every slave, plus one active-low select per slave. A selected slave takes in a command frame on the command line and performs a register read or write on a parallel register port that may take any number of cycles. It then reports completion on the response line with an acknowledge frame. Only the selected slave ever enables its response driver, so many slaves can share one response wire.

While the internal access is in progress, the slave holds the response line low. The master waits for the rising start bit of the acknowledge instead of polling or assuming a fixed transfer length, which lets the slave stall the master for as long as the register port needs. Dropping the select at any point abandons the transaction. The block is clocked directly by the bus clock and samples the command line on its rising edge.

Top module: `ctl_serial_slave`

## Requirements
- R1: After reset the response enable `rsp_oe` is 0 and `reg_req` is 0.
- R2: A write frame is a 1 start bit, then the direction bit set to 1, a 6-bit operation code, a 12-bit address and 32 data bits. All fields are sent MSB first on `cmd_in` and sampled on rising edges while `sel_n` is 0. The slave then raises `reg_req` with `reg_wr`=1 and those op, address and data values.
- R3: A read frame is a 1 start bit, the direction bit set to 0, the 6-bit op code and the 12-bit address, with no data bits. It produces a request with `reg_wr`=0 and those op and address values.
- R4: From the edge that samples the last frame bit until the edge on which `reg_ack` is seen with `reg_req`, `rsp_oe` is 1 and `rsp_out` is 0. `reg_req` and all request fields hold steady during this time. With the acknowledge given L cycles after `reg_req` rises, the response line is low for exactly L+1 cycles.
- R5: In the cycle after the acknowledge edge, `rsp_out` shows a 1 start bit. One bit per cycle then follows: the direction bit, op code and address echoed MSB first, and for reads the 32 bits of `reg_rdata` captured at the acknowledge edge.
- R6: `rsp_oe` falls in the same cycle that `sel_n` goes high. A rising edge with `sel_n` high drops `reg_req` and returns the slave to idle from any phase. An aborted frame causes no register access.
- R7: While selected and idle, a 0 on `cmd_in` is ignored: no request is made and the response line is not enabled.
- R8: After the last response bit the slave releases the response line and accepts the next start bit without being reselected. Receive, access wait and response never overlap.
- R9: While `sel_n` is high, traffic on `cmd_in` causes no request and leaves the response line disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock; command sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select dedicated to this slave |
| cmd_in | input | 1 | Shared serial command line |
| rsp_out | output | 1 | Response data, forced to 0 when not enabled |
| rsp_oe | output | 1 | Response driver enable |
| reg_req | output | 1 | Register access request, held until acknowledge |
| reg_wr | output | 1 | 1 for write, 0 for read |
| reg_op | output | 6 | Operation code from the frame |
| reg_addr | output | 12 | Register address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Register access acknowledge |
| reg_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
The assertions check on every cycle that the three phases never overlap and that a request only follows a completed frame. They also check that the request and its fields hold until acknowledged, that the response stays low during the wait, that the response shifter starts only after a handshake, and that a high select empties every phase. Only the bench scenarios can show that the fields reach the register port intact and that the acknowledge frame echoes them bit for bit with the right read data. They also show that the wait lasts exactly as long as the acknowledge latency, and that aborted or deselected frames leave register contents untouched.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  // number of bits the slave samples after the start bit
  function automatic int rx_bits(input bit wr, input int hdr_w, input int data_w);
    return wr ? hdr_w + data_w : hdr_w;
  endfunction

  // number of bits in the acknowledge frame, start bit included
  function automatic int tx_bits(input bit wr, input int hdr_w, input int data_w);
    return wr ? 1 + hdr_w : 1 + hdr_w + data_w;
  endfunction
endpackage

// File: rtl/ssl_rx.sv
module ssl_rx #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_in,
  input  logic              enable,
  output logic              busy,
  output logic              frame_done,
  output logic              f_wr,
  output logic [OP_W-1:0]   f_op,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_wdata
);
  localparam int HDR_W = 1 + OP_W + ADDR_W;
  localparam int SH_W  = HDR_W + DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q, sh_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q, busy_q, wr_now;
  logic [HDR_W-1:0] hdr;

  assign wr_now     = (cnt_q == '0) ? cmd_in : wr_q;
  assign sh_nx      = {sh_q[SH_W-2:0], cmd_in};
  assign frame_done = busy_q && !sel_n &&
                      (int'(cnt_q) == ssl_pkg::rx_bits(wr_now, HDR_W, DATA_W) - 1);
  assign hdr        = wr_now ? sh_nx[SH_W-1 -: HDR_W] : sh_nx[HDR_W-1:0];
  assign f_wr       = hdr[HDR_W-1];
  assign f_op       = hdr[HDR_W-2 -: OP_W];
  assign f_addr     = hdr[ADDR_W-1:0];
  assign f_wdata    = wr_now ? sh_nx[DATA_W-1:0] : '0;
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      wr_q   <= 1'b0;
    end else if (sel_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (enable && cmd_in) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sh_q   <= '0;
      end
    end else if (frame_done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sh_q  <= sh_nx;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) wr_q <= cmd_in;
    end
  end
endmodule

// File: rtl/ssl_req.sv
module ssl_req #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              start,
  input  logic              s_wr,
  input  logic [OP_W-1:0]   s_op,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              reg_ack,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [OP_W-1:0]   reg_op,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              acc_done
);
  assign acc_done = reg_req && reg_ack && !sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_req   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_op    <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (sel_n) begin
      reg_req <= 1'b0;
    end else if (start) begin
      reg_req   <= 1'b1;
      reg_wr    <= s_wr;
      reg_op    <= s_op;
      reg_addr  <= s_addr;
      reg_wdata <= s_wdata;
    end else if (acc_done) begin
      reg_req <= 1'b0;
    end
  end
endmodule

// File: rtl/ssl_tx.sv
module ssl_tx #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              load,
  input  logic              l_wr,
  input  logic [OP_W-1:0]   l_op,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_rdata,
  output logic              busy,
  output logic              tx_bit,
  output logic              tx_last
);
  localparam int HDR_W = 1 + OP_W + ADDR_W;
  localparam int TX_W  = 1 + HDR_W + DATA_W;
  localparam int CNT_W = $clog2(TX_W + 1);

  logic [TX_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q, busy_q;

  assign busy    = busy_q;
  assign tx_bit  = sh_q[TX_W-1];
  assign tx_last = busy_q &&
                   (int'(cnt_q) == ssl_pkg::tx_bits(wr_q, HDR_W, DATA_W) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      wr_q   <= 1'b0;
    end else if (sel_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      wr_q   <= l_wr;
      sh_q   <= {1'b1, l_wr, l_op, l_addr, (l_wr ? {DATA_W{1'b0}} : l_rdata)};
    end else if (busy_q) begin
      if (tx_last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        sh_q  <= {sh_q[TX_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_serial_slave.sv
module ctl_serial_slave #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_in,
  output logic              rsp_out,
  output logic              rsp_oe,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [OP_W-1:0]   reg_op,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [DATA_W-1:0] reg_rdata
);
  // named internal events, observed by the bound checker
  logic              rx_busy, frame_done, acc_done, tx_busy, tx_bit, tx_last;
  logic              f_wr;
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_wdata;
  logic              rx_enable;

  assign rx_enable = !(reg_req || tx_busy);

  ssl_rx #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_in(cmd_in), .enable(rx_enable),
    .busy(rx_busy), .frame_done(frame_done), .f_wr(f_wr), .f_op(f_op),
    .f_addr(f_addr), .f_wdata(f_wdata)
  );

  ssl_req #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .start(frame_done),
    .s_wr(f_wr), .s_op(f_op), .s_addr(f_addr), .s_wdata(f_wdata),
    .reg_ack(reg_ack), .reg_req(reg_req), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .acc_done(acc_done)
  );

  ssl_tx #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .load(acc_done),
    .l_wr(reg_wr), .l_op(reg_op), .l_addr(reg_addr), .l_rdata(reg_rdata),
    .busy(tx_busy), .tx_bit(tx_bit), .tx_last(tx_last)
  );

  // driver released the moment select goes high; low while the access waits
  assign rsp_oe  = !sel_n && (reg_req || tx_busy);
  assign rsp_out = rsp_oe && tx_busy && tx_bit;
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              rsp_out,
  input logic              reg_req,
  input logic              reg_ack,
  input logic              reg_wr,
  input logic [OP_W-1:0]   reg_op,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rx_busy,
  input logic              frame_done,
  input logic              acc_done,
  input logic              tx_busy
);
  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !(rx_busy || reg_req || tx_busy));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack && !sel_n) |=> reg_req);

  assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack && !sel_n) |=> $stable({reg_wr, reg_op, reg_addr, reg_wdata}));

  assert_wait_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !rsp_out);

  assert_req_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) |-> $past(frame_done));

  assert_tx_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(acc_done));

  assert_phase_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_busy, reg_req, tx_busy}));
endmodule

bind ctl_serial_slave ssl_checker #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rsp_out(rsp_out), .reg_req(reg_req),
  .reg_ack(reg_ack), .reg_wr(reg_wr), .reg_op(reg_op), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rx_busy(rx_busy), .frame_done(frame_done),
  .acc_done(acc_done), .tx_busy(tx_busy)
);

// File: tb/test_ctl_serial_slave.sv
module test_ctl_serial_slave;
  logic        clk = 1'b0;
  logic        rst_n, sel_n, cmd_in, rsp_out, rsp_oe;
  logic        reg_req, reg_wr, reg_ack;
  logic [5:0]  reg_op;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  ctl_serial_slave i_ctl_serial_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_in(cmd_in), .rsp_out(rsp_out),
    .rsp_oe(rsp_oe), .reg_req(reg_req), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  int vec = 0, miss = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // register port model: acknowledges after lat idle cycles
  int          lat = 0, wcnt = 0, hs_cnt = 0;
  logic [31:0] mem [16];
  logic        got_wr;
  logic [5:0]  got_op;
  logic [11:0] got_addr;
  logic [31:0] got_wdata;

  always @(negedge clk) begin
    if (reg_req) begin
      if (wcnt >= lat) begin
        reg_ack   = 1'b1;
        got_wr    = reg_wr;
        got_op    = reg_op;
        got_addr  = reg_addr;
        got_wdata = reg_wdata;
        if (reg_wr) mem[reg_addr[3:0]] = reg_wdata;
        reg_rdata = mem[reg_addr[3:0]];
        hs_cnt++;
        wcnt = 0;
      end else begin
        reg_ack = 1'b0;
        wcnt++;
      end
    end else begin
      reg_ack = 1'b0;
      wcnt    = 0;
    end
  end

  logic [31:0] shadow [16];

  task automatic send_bits(input logic [51:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_in = f[51-i];
    end
  endtask

  task automatic transact(input bit wr, input logic [5:0] op, input logic [11:0] addr,
                          input logic [31:0] d, input int l);
    int          low;
    int          hs0;
    bit          bad;
    logic [51:0] r;
    int          n;
    logic [31:0] exp_rd;
    lat    = l;
    hs0    = hs_cnt;
    exp_rd = shadow[addr[3:0]];
    send_bits({1'b1, wr, op, addr, d}, wr ? 52 : 20);
    low = 0;
    bad = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      cmd_in = 1'b0;
      if (rsp_oe && rsp_out) break;
      if (rsp_oe && !rsp_out) low++;
      else bad = 1;
    end
    chk("R4 response low during wait", 64'(low), 64'(l + 1));
    chk("R4 enable held during wait", 64'(bad), 64'd0);
    r = '0;
    r[51] = 1'b1;
    n = wr ? 20 : 52;
    bad = 0;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      r[51-i] = rsp_out;
      if (!rsp_oe) bad = 1;
    end
    chk("R5 enable through response", 64'(bad), 64'd0);
    chk(wr ? "R2 request fields" : "R3 request fields",
        {got_wr, got_op, got_addr}, {wr, op, addr});
    if (wr) begin
      chk("R2 write data", 64'(got_wdata), 64'(d));
      shadow[addr[3:0]] = d;
    end
    chk("R5 echoed header", 64'(r[50:32]), 64'({wr, op, addr}));
    if (!wr) chk("R5 read data", 64'(r[31:0]), 64'(exp_rd));
    chk("R5 one access", 64'(hs_cnt - hs0), 64'd1);
    @(negedge clk);
    chk("R8 line released after response", 64'(rsp_oe), 64'd0);
  endtask

  initial begin
    #1_500_000;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    int h0;
    bit bad;
    for (int i = 0; i < 16; i++) begin
      mem[i]    = '0;
      shadow[i] = '0;
    end
    reg_ack = 1'b0; reg_rdata = '0;
    rst_n = 1'b0; sel_n = 1'b1; cmd_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset enable", 64'(rsp_oe), 64'd0);
    chk("R1 reset request", 64'(reg_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: frames while deselected are ignored
    h0 = hs_cnt;
    bad = 0;
    for (int i = 0; i < 52; i++) begin
      @(negedge clk);
      cmd_in = ({1'b1, 1'b1, 6'h3F, 12'h005, 32'hFFFF_FFFF} >> (51 - i)) & 1;
      if (rsp_oe || reg_req) bad = 1;
    end
    repeat (5) begin
      @(negedge clk);
      cmd_in = 1'b0;
      if (rsp_oe || reg_req) bad = 1;
    end
    chk("R9 deselected no activity", 64'(bad), 64'd0);
    chk("R9 deselected no access", 64'(hs_cnt - h0), 64'd0);

    // R7: idle zeros ignored
    sel_n = 1'b0;
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (rsp_oe || reg_req) bad = 1;
    end
    chk("R7 idle zeros ignored", 64'(bad), 64'd0);

    // sweep of writes and reads across latencies, back to back (R8)
    for (int l = 0; l < 4; l++) begin
      for (int k = 0; k < 6; k++) begin
        logic [11:0] a;
        logic [5:0]  o;
        logic [31:0] d;
        a = 12'((k * 12'h247) ^ (l * 12'h0B1));
        o = 6'((k * 5 + l * 11) & 63);
        d = 32'hA500_0000 ^ (k << 8) ^ (l * 32'h0001_1111) ^ (32'(a) << 12);
        transact(1'b1, o, a, d, l);
        transact(1'b0, o ^ 6'h2A, a, 32'h0, 3 - l);
      end
    end

    // R6: abort part way through a write frame
    h0 = hs_cnt;
    send_bits({1'b1, 1'b1, 6'h11, 12'h003, 32'hDEAD_BEEF}, 10);
    @(negedge clk);
    cmd_in = 1'b0;
    sel_n  = 1'b1;
    #1 chk("R6 enable dropped on deselect", 64'(rsp_oe), 64'd0);
    @(negedge clk);
    chk("R6 no request after abort", 64'(reg_req), 64'd0);
    sel_n = 1'b0;
    transact(1'b0, 6'h01, 12'h003, 32'h0, 1);
    chk("R6 aborted write had no access", 64'(hs_cnt - h0), 64'd1);

    // R6: abort while waiting for acknowledge
    lat = 40;
    h0 = hs_cnt;
    send_bits({1'b1, 1'b0, 6'h05, 12'h007, 32'h0}, 20);
    repeat (3) @(negedge clk);
    cmd_in = 1'b0;
    chk("R4 waiting enable", 64'(rsp_oe), 64'd1);
    sel_n = 1'b1;
    #1 chk("R6 enable dropped during wait", 64'(rsp_oe), 64'd0);
    @(negedge clk);
    chk("R6 request dropped", 64'(reg_req), 64'd0);
    chk("R6 no access on abort", 64'(hs_cnt - h0), 64'd0);
    sel_n = 1'b0;

    // R6: abort during response
    lat = 0;
    send_bits({1'b1, 1'b0, 6'h09, 12'h00C, 32'h0}, 20);
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      cmd_in = 1'b0;
      if (rsp_out) break;
    end
    repeat (5) @(negedge clk);
    sel_n = 1'b1;
    #1 chk("R6 response line released", 64'({rsp_oe, rsp_out}), 64'd0);
    @(negedge clk);
    sel_n = 1'b0;
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (rsp_oe || reg_req) bad = 1;
    end
    chk("R6 idle after response abort", 64'(bad), 64'd0);
    transact(1'b1, 6'h3F, 12'hFFF, 32'hFFFF_FFFF, 2);
    transact(1'b0, 6'h00, 12'hFFF, 32'h0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule